// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a master for a four-wire serial peripheral bus. The host pushes bytes into an eight-entry transmit queue. The block sends each byte as an 8-bit frame, most significant bit first, on `sclk_o` and `mosi_o`, with the chip select `cs_no` held low. At the same time it captures the bits that arrive on `miso_i` into an eight-entry receive queue, which the host drains with a pop strobe. A stream is a run of bytes that are already queued. The block sends such a stream on its own, with no host action between bytes.

The clock polarity and phase come from `mode_i`. The serial clock is the system clock divided by the even value on `div_i`. Phase decides how back-to-back frames join. With phase 0, the block lets the serial clock rest for exactly one full period between frames and raises the chip select during that period. With phase 1, the clock runs on from one frame into the next without a pause.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, `cs_no` is 1, `sclk_o` is 0, `mosi_o` is 0, `busy_o` is 0, `ovf_o` is 0, `tx_full_o` is 0 and `rx_valid_o` is 0.
- R2: Bit 1 of `mode_i` is the idle clock level and bit 0 is the phase. While the block is idle, `sclk_o` follows `mode_i[1]` one cycle later.
- R3: Every serial clock half-period lasts `div_i/2` system clocks. A `div_i` below 2 counts as 2.
- R4: A frame is 8 bits, MSB first. With phase 0, `mosi_o` carries the MSB from the cycle in which `cs_no` falls, changes on trailing edges, and `miso_i` is sampled on leading edges. With phase 1, `mosi_o` changes on leading edges and `miso_i` is sampled on trailing edges.
- R5: With phase 0, the 16th edge of a frame raises `cs_no`. It then stays high for two half-periods. If a byte is queued, the next frame then starts at once, and its first edge follows one half-period later.
- R6: With phase 1 and the next byte queued at the 16th edge, the next frame's first edge follows one half-period later and `cs_no` stays low.
- R7: With phase 1 and the queue empty at the 16th edge, `cs_no` rises one half-period after that edge.
- R8: A byte accepted at a clock edge lowers `cs_no` and raises `busy_o` at the next edge, if the block was idle. `busy_o` falls when `cs_no` rises at the end of the stream. With phase 0, that is after the trailing gap.
- R9: The transmit queue holds 8 bytes and `tx_full_o` reports when it is full. A write while it is full is dropped and sets `ovf_o`. `ovf_o` stays set until reset.
- R10: Received bytes come out of `rx_data_o` in arrival order while `rx_valid_o` is 1, and `rx_pop_i` removes one. A byte that completes while the receive queue holds 8 is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | [1] idle clock level, [0] phase |
| div_i | input | 8 | System clocks per serial clock period (even) |
| tx_data_i | input | 8 | Byte to queue |
| tx_valid_i | input | 1 | Write strobe for tx_data_i |
| tx_full_o | output | 1 | Transmit queue full |
| ovf_o | output | 1 | Sticky dropped-write flag |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_pop_i | input | 1 | Removes the oldest received byte |
| busy_o | output | 1 | Stream in progress |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest moments to reach are the frame joins. Here the engine decides, at the 16th edge, whether a queued byte exists, while host writes and the overflow check land on nearby cycles. The stimulus writes bursts of consecutive bytes in every mode and at several dividers. One burst writes ten bytes into a slow stream, so the transmit queue fills, a write is dropped, and more frames arrive than the receive queue can hold. A reference model in the bench tracks the queue contents and the expected pins on every clock.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2,
    ST_HOLD = 2'd3
  } spim_state_e;

  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned EDGES      = 2 * FRAME_BITS;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_wr, do_rd;

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign do_wr     = wr_i && !full_o;
  assign do_rd     = rd_i && !empty_o;
  assign rd_data_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wr_data_i;
  end

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r9_full_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> full_o);
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned HW = DIV_W - 1;

  logic [HW-1:0] half, cnt_q;

  // odd values round down, anything under 2 behaves as 2
  assign half   = (div_i[DIV_W-1:1] == '0) ? HW'(1) : div_i[DIV_W-1:1];
  assign tick_o = run_i && (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tick_i,
  input  logic       tx_empty_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_pop_o,
  output logic       rx_push_o,
  output logic [7:0] rx_data_o,
  output logic       run_o,
  output logic       busy_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       cs_no,
  input  logic       miso_i
);
  spim_state_e st_q;
  logic [3:0]  edge_q;
  logic [7:0]  sh_q, rx_sh_q;
  logic        cpha_q, gap_q, sclk_q, mosi_q, cs_q, was_idle_q;
  logic        last_edge, lead, sample, load;

  assign last_edge = (edge_q == 4'(EDGES - 1));
  assign lead      = !edge_q[0];
  assign sample    = lead ^ cpha_q;

  always_comb begin
    load = 1'b0;
    unique case (st_q)
      ST_IDLE: load = !tx_empty_i;
      ST_RUN:  load = tick_i && last_edge && cpha_q && !tx_empty_i;
      ST_GAP:  load = tick_i && gap_q && !tx_empty_i;
      default: load = 1'b0;
    endcase
  end

  assign tx_pop_o  = load;
  assign rx_push_o = (st_q == ST_RUN) && tick_i && last_edge;
  assign rx_data_o = cpha_q ? {rx_sh_q[6:0], miso_i} : rx_sh_q;
  assign run_o     = (st_q != ST_IDLE);
  assign busy_o    = run_o;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;
  assign cs_no     = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      edge_q  <= '0;
      sh_q    <= '0;
      rx_sh_q <= '0;
      cpha_q  <= 1'b0;
      gap_q   <= 1'b0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sclk_q <= mode_i[1];
          cs_q   <= 1'b1;
          cpha_q <= mode_i[0];
        end
        ST_RUN: if (tick_i) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (sample) begin
            rx_sh_q <= {rx_sh_q[6:0], miso_i};
          end else if (!(last_edge && !cpha_q)) begin
            mosi_q <= cpha_q ? sh_q[7] : sh_q[6];
            sh_q   <= {sh_q[6:0], 1'b0};
          end
          if (last_edge) begin
            if (!cpha_q) begin
              cs_q  <= 1'b1;
              gap_q <= 1'b0;
              st_q  <= ST_GAP;
            end else if (tx_empty_i) begin
              st_q <= ST_HOLD;
            end
          end
        end
        ST_GAP: if (tick_i) begin
          gap_q <= 1'b1;
          if (gap_q && tx_empty_i) st_q <= ST_IDLE;
        end
        ST_HOLD: if (tick_i) begin
          cs_q <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      // a queued byte starts a frame; the phase is taken only when leaving idle
      if (load) begin
        st_q   <= ST_RUN;
        edge_q <= '0;
        cs_q   <= 1'b0;
        sh_q   <= tx_data_i;
        if (st_q == ST_IDLE ? !mode_i[0] : !cpha_q) mosi_q <= tx_data_i[7];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_idle_q <= 1'b0;
    else         was_idle_q <= (st_q == ST_IDLE);
  end

  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && was_idle_q && $stable(mode_i)) |-> (sclk_q == mode_i[1]));
  a_r5_gap_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP) |-> cs_q);
  a_r6_run_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> !cs_q);
  a_r7_hold_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && tick_i) |=> (cs_q && st_q == ST_IDLE));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_full_o,
  output logic             ovf_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_pop_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_no,
  input  logic             miso_i
);
  logic       tx_empty, tx_pop, rx_push, rx_empty, rx_full_unused, tick, run;
  logic [7:0] tx_head, rx_word;
  logic       ovf_q;

  spim_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .wr_i(tx_valid_i), .wr_data_i(tx_data_i),
    .rd_i(tx_pop), .rd_data_o(tx_head),
    .full_o(tx_full_o), .empty_o(tx_empty)
  );

  spim_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .wr_i(rx_push), .wr_data_i(rx_word),
    .rd_i(rx_pop_i), .rd_data_o(rx_data_o),
    .full_o(rx_full_unused), .empty_o(rx_empty)
  );

  spim_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .div_i, .tick_o(tick)
  );

  spim_engine u_eng (
    .clk_i, .rst_ni, .mode_i, .tick_i(tick),
    .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_word),
    .run_o(run), .busy_o, .sclk_o, .mosi_o, .cs_no, .miso_i
  );

  assign rx_valid_o = !rx_empty;
  assign ovf_o      = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (tx_valid_i && tx_full_o) ovf_q <= 1'b1;
  end

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r9_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(tx_valid_i && tx_full_o));
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] div_i = 8'd4;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       rx_pop_i = 1'b0;
  logic       miso_i = 1'b0;
  logic       tx_full_o, ovf_o, rx_valid_o, busy_o, sclk_o, mosi_o, cs_no;
  logic [7:0] rx_data_o;

  always #4 clk_i = ~clk_i;

  spi_fifo_master dut_i (
    .clk_i, .rst_ni, .mode_i, .div_i, .tx_data_i, .tx_valid_i, .tx_full_o,
    .ovf_o, .rx_data_o, .rx_valid_o, .rx_pop_i, .busy_o, .sclk_o, .mosi_o,
    .cs_no, .miso_i
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cs_tag = "R5";

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0] mq[$];
  logic [7:0] rq[$];
  logic [7:0] pend;
  bit pend_v = 0, started = 0;
  bit e_sclk = 0, e_mosi = 0, e_cs = 1, e_busy = 0, e_ovf = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk_i) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso_i <= lfsr[15];
  end

  task automatic step();
    @(posedge clk_i);
    if (pend_v) mq.push_back(pend);
    pend_v = 0;
    if (tx_valid_i) begin
      if (mq.size() < 8) begin pend_v = 1; pend = tx_data_i; end
      else e_ovf = 1;
    end
  endtask

  initial begin : model
    @(posedge rst_ni);
    started = 1;
    forever begin
      step();
      e_sclk = mode_i[1];
      if (mq.size() > 0) begin
        automatic bit cpha = mode_i[0];
        automatic int h = (div_i / 2 < 1) ? 1 : div_i / 2;
        automatic bit more = 1;
        automatic logic [7:0] b = mq.pop_front();
        e_busy = 1; e_cs = 0;
        if (!cpha) e_mosi = b[7];
        while (more) begin
          automatic logic [7:0] rx = 0;
          for (int k = 1; k <= 16; k++) begin
            repeat (h) step();
            e_sclk = ~e_sclk;
            if ((k % 2 == 1) != cpha) rx = {rx[6:0], miso_i};
            else if (cpha) e_mosi = b[7 - (k - 1) / 2];
            else if (k < 16) e_mosi = b[7 - k / 2];
          end
          if (rq.size() < 8) rq.push_back(rx);
          if (!cpha) begin
            e_cs = 1;
            repeat (2 * h) step();
            if (mq.size() > 0) begin
              b = mq.pop_front(); e_cs = 0; e_mosi = b[7];
            end else more = 0;
          end else if (mq.size() > 0) begin
            b = mq.pop_front();
          end else begin
            repeat (h) step();
            e_cs = 1; more = 0;
          end
        end
        e_busy = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    cycles++;
    if (started) begin
      check("R3 sclk", sclk_o, e_sclk);
      check("R4 mosi", mosi_o, e_mosi);
      check({cs_tag, " cs_n"}, cs_no, e_cs);
      check("R8 busy", busy_o, e_busy);
      check("R9 tx_full", tx_full_o, (mq.size() + pend_v) >= 8);
      check("R9 ovf", ovf_o, e_ovf);
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      tx_valid_i = 1; tx_data_i = base + 8'(i * 37);
    end
    @(posedge clk_i); #1;
    tx_valid_i = 0;
  endtask

  task automatic settle();
    do @(negedge clk_i); while (e_busy || mq.size() > 0 || pend_v);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic drain(input string req);
    while (rq.size() > 0) begin
      @(negedge clk_i);
      check({req, " rx_valid"}, rx_valid_o, 1);
      check({req, " rx_data"}, rx_data_o, rq[0]);
      rx_pop_i = 1;
      @(posedge clk_i); #1;
      rx_pop_i = 0;
      void'(rq.pop_front());
    end
    @(negedge clk_i);
    check({req, " rx_empty"}, rx_valid_o, 0);
  endtask

  task automatic run(input logic [1:0] m, input logic [7:0] d, input int n,
                     input logic [7:0] base, input string tag);
    @(posedge clk_i); #1;
    mode_i = m; div_i = d; cs_tag = tag;
    repeat (2) @(negedge clk_i);
    check("R2 idle sclk level", sclk_o, m[1]);
    burst(n, base);
    settle();
    drain("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 cs_n", cs_no, 1);
    check("R1 sclk", sclk_o, 0);
    check("R1 mosi", mosi_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 ovf", ovf_o, 0);
    check("R1 tx_full", tx_full_o, 0);
    check("R1 rx_valid", rx_valid_o, 0);
    rst_ni = 1;
    run(2'd0, 8'd4, 3, 8'hA5, "R5");
    run(2'd1, 8'd2, 4, 8'h3C, "R6/R7");
    run(2'd2, 8'd6, 2, 8'h81, "R5");
    run(2'd3, 8'd4, 3, 8'h0F, "R6/R7");
    run(2'd0, 8'd0, 1, 8'hC3, "R3 clamp R5");
    run(2'd1, 8'd8, 10, 8'h11, "R9 R6");
    check("R9 ovf kept", ovf_o, 1);
    run(2'd2, 8'd2, 2, 8'h55, "R5");
    check("R9 ovf sticky", ovf_o, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule